// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps a small, fully associative table of cache lines whose miss is outstanding at the next memory level. Each table entry is keyed by a block address. It holds a short list of requester IDs that wait for that line, and a flag that records whether any of those requests is atomic. When a second or later request for a line that is still waiting arrives, it is merged into the existing entry and does not allocate a new one. Merging stops at a fixed limit per entry.

When the line returns, the fill is presented with its block address. The matching entry joins the back of a queue of completed entries, and the fill cycle reports the entry's atomic flag. The waiting IDs then leave through a ready port, one ID for each pop. An entry is emptied completely before the next queued entry is served. The entry becomes free at the pop of its last ID.

A lookup port lets the requester ask, before issuing, whether the address is already outstanding and whether a new request for it could be tracked. The block holds no line data and issues no memory requests.

Top module: `mshr_table`

## Requirements
- R1: After reset the table holds no entries: `rdy_valid` is low, and `probe_hit` and `probe_full` are low for every address.
- R2: `probe_hit` is high, combinationally, when an entry that has not yet been filled holds `probe_addr`. This holds from the cycle after the accepting add.
- R3: `probe_full` is high when the matching unfilled entry already holds MAX_MERGE IDs, or when there is no match and every entry is occupied. An add whose address meets the same condition is dropped: `add_ok` is low and the table is unchanged.
- R4: An accepted add to an address with an unfilled matching entry appends its ID to that entry. Otherwise the add claims a free entry with this ID as its first.
- R5: A fill whose address matches an unfilled entry queues that entry, and `rdy_valid` is high from the next cycle. A fill that matches no unfilled entry has no effect.
- R6: In a fill cycle, `fill_atomic` is high exactly when the matched entry holds at least one request that was added with `add_atomic` high.
- R7: The IDs of one entry appear on `rdy_id` in the order they were added, advancing by one per `rdy_pop`. `rdy_last` is high with the final ID.
- R8: Queued entries are drained in the order their fills arrived.
- R9: Popping the final ID frees the entry. From the next cycle its address no longer probes as a hit, the slot can be claimed again, and its atomic flag starts clear.
- R10: A filled entry is no longer matched by probe, add or fill. An add to its address claims a separate fresh entry, which a later fill matches.
- R11: `rdy_pop` while `rdy_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_addr | input | ADDR_W | Block address to look up |
| probe_hit | output | 1 | Address has an unfilled outstanding entry |
| probe_full | output | 1 | A new request to probe_addr could not be tracked |
| add_valid | input | 1 | Add a request this cycle |
| add_addr | input | ADDR_W | Block address of the added request |
| add_id | input | ID_W | Requester ID to store |
| add_atomic | input | 1 | Added request is atomic |
| add_ok | output | 1 | Add is accepted this cycle |
| fill_valid | input | 1 | A line returned this cycle |
| fill_addr | input | ADDR_W | Block address of the returned line |
| fill_atomic | output | 1 | Filled entry holds an atomic request |
| rdy_valid | output | 1 | A waiting ID is available |
| rdy_id | output | ID_W | Oldest waiting ID of the entry being drained |
| rdy_last | output | 1 | rdy_id is the final ID of its entry |
| rdy_pop | input | 1 | Consume rdy_id |

## Verification
The hardest state to reach is a table in which every slot is occupied and one matching entry still has room. In that state a probe to a new address must report full, while a probe to that entry's address must not. A second hard case is an address that has two entries at once, one filled and draining and one fresh. The directed sequences fill all slots with distinct lines and then merge into one of them. Separately, they fill a line and re-add its address before the first pop, so the drain shows both IDs come out of separate entries.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  // Width of an index into a set of n items (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of a counter that must hold values 0..m.
  function automatic int cnt_width(input int m);
    return $clog2(m + 1);
  endfunction

  // Modulo-n increment of a pointer.
  function automatic int wrap_next(input int p, input int n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  parameter int IW     = 2
) (
  input  logic [N-1:0]      ent_live,
  input  logic [ADDR_W-1:0] ent_addr [N],
  input  logic [ADDR_W-1:0] key,
  output logic              hit,
  output logic [IW-1:0]     hit_idx
);
  // Lowest-index live entry whose address equals key.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ent_live[i] && (ent_addr[i] == key)) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_ready_fifo.sv
module mshr_ready_fifo #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [IW-1:0] head_idx,
  output logic          nonempty
);
  import mshr_pkg::*;
  localparam int PW = idx_width(N);
  localparam int LW = cnt_width(N);

  logic [IW-1:0] slot [N];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level;

  assign head_idx = slot[rd_ptr];
  assign nonempty = (level != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(wrap_next(int'(wr_ptr), N));
      if (pop)  rd_ptr <= PW'(wrap_next(int'(rd_ptr), N));
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= push_idx;
  end
endmodule

// File: rtl/mshr_table.sv
module mshr_table #(
  parameter int ENTRIES   = 4,
  parameter int MAX_MERGE = 3,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              probe_full,
  input  logic              add_valid,
  input  logic [ADDR_W-1:0] add_addr,
  input  logic [ID_W-1:0]   add_id,
  input  logic              add_atomic,
  output logic              add_ok,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              fill_atomic,
  output logic              rdy_valid,
  output logic [ID_W-1:0]   rdy_id,
  output logic              rdy_last,
  input  logic              rdy_pop
);
  import mshr_pkg::*;
  localparam int IW = idx_width(ENTRIES);
  localparam int CW = cnt_width(MAX_MERGE);
  localparam int SW = idx_width(MAX_MERGE);

  // Entry state
  logic [ENTRIES-1:0] v_vec;        // occupied
  logic [ENTRIES-1:0] filled_vec;   // line returned, draining
  logic [ENTRIES-1:0] atom_vec;     // holds an atomic request
  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  logic [CW-1:0]      ent_cnt  [ENTRIES];
  logic [CW-1:0]      ent_rdp  [ENTRIES];
  logic [ID_W-1:0]    ent_ids  [ENTRIES][MAX_MERGE];

  logic [ENTRIES-1:0] live_vec;
  assign live_vec = v_vec & ~filled_vec;

  // Lookups
  logic          p_hit, a_hit, f_hit;
  logic [IW-1:0] p_idx, a_idx, f_idx;

  mshr_match #(.N(ENTRIES), .ADDR_W(ADDR_W), .IW(IW)) u_probe_match (
    .ent_live(live_vec), .ent_addr(ent_addr), .key(probe_addr),
    .hit(p_hit), .hit_idx(p_idx));
  mshr_match #(.N(ENTRIES), .ADDR_W(ADDR_W), .IW(IW)) u_add_match (
    .ent_live(live_vec), .ent_addr(ent_addr), .key(add_addr),
    .hit(a_hit), .hit_idx(a_idx));
  mshr_match #(.N(ENTRIES), .ADDR_W(ADDR_W), .IW(IW)) u_fill_match (
    .ent_live(live_vec), .ent_addr(ent_addr), .key(fill_addr),
    .hit(f_hit), .hit_idx(f_idx));

  // Lowest free slot
  logic          room;
  logic [IW-1:0] room_idx;
  always_comb begin
    room     = 1'b0;
    room_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!v_vec[i]) begin
        room     = 1'b1;
        room_idx = IW'(i);
      end
    end
  end

  function automatic logic cannot_track(input logic hit, input logic [CW-1:0] cnt,
                                        input logic free_any);
    return hit ? (cnt == CW'(MAX_MERGE)) : !free_any;
  endfunction

  assign probe_hit  = p_hit;
  assign probe_full = cannot_track(p_hit, ent_cnt[p_idx], room);

  // Named internal events
  logic          add_full, alloc_ev, merge_ev, fill_hit_ev, pop_ev, free_ev;
  logic [IW-1:0] tgt_idx, head_idx;
  logic          q_nonempty;

  assign add_full    = cannot_track(a_hit, ent_cnt[a_idx], room);
  assign add_ok      = add_valid && !add_full;
  assign merge_ev    = add_ok && a_hit;
  assign alloc_ev    = add_ok && !a_hit;
  assign tgt_idx     = a_hit ? a_idx : room_idx;
  assign fill_hit_ev = fill_valid && f_hit;
  assign fill_atomic = fill_hit_ev && atom_vec[f_idx];

  assign rdy_valid = q_nonempty;
  assign rdy_id    = ent_ids[head_idx][SW'(ent_rdp[head_idx])];
  assign rdy_last  = (ent_rdp[head_idx] + CW'(1)) == ent_cnt[head_idx];
  assign pop_ev    = rdy_pop && q_nonempty;
  assign free_ev   = pop_ev && rdy_last;

  mshr_ready_fifo #(.N(ENTRIES), .IW(IW)) u_ready_q (
    .clk(clk), .rst_n(rst_n),
    .push(fill_hit_ev), .push_idx(f_idx),
    .pop(free_ev), .head_idx(head_idx), .nonempty(q_nonempty));

  // Entry control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_vec      <= '0;
      filled_vec <= '0;
      atom_vec   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_cnt[i] <= '0;
        ent_rdp[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_ev && tgt_idx == IW'(i)) begin
          v_vec[i]      <= 1'b1;
          filled_vec[i] <= 1'b0;
          atom_vec[i]   <= add_atomic;
          ent_cnt[i]    <= CW'(1);
          ent_rdp[i]    <= '0;
        end else if (merge_ev && tgt_idx == IW'(i)) begin
          atom_vec[i] <= atom_vec[i] | add_atomic;
          ent_cnt[i]  <= ent_cnt[i] + CW'(1);
        end
        if (fill_hit_ev && f_idx == IW'(i)) filled_vec[i] <= 1'b1;
        if (pop_ev && head_idx == IW'(i)) begin
          if (rdy_last) begin
            v_vec[i]      <= 1'b0;
            filled_vec[i] <= 1'b0;
            atom_vec[i]   <= 1'b0;
            ent_cnt[i]    <= '0;
            ent_rdp[i]    <= '0;
          end else begin
            ent_rdp[i] <= ent_rdp[i] + CW'(1);
          end
        end
      end
    end
  end

  // Address and ID storage (no reset needed)
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_ev && tgt_idx == IW'(i)) begin
        ent_addr[i]    <= add_addr;
        ent_ids[i][0]  <= add_id;
      end else if (merge_ev && tgt_idx == IW'(i)) begin
        ent_ids[i][SW'(ent_cnt[i])] <= add_id;
      end
    end
  end
endmodule

// File: rtl/mshr_table_chk.sv
module mshr_table_chk #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] v_vec,
  input logic               alloc_ev,
  input logic               fill_hit_ev,
  input logic               pop_ev,
  input logic               free_ev,
  input logic               rdy_valid,
  input logic               rdy_last,
  input logic               rdy_pop
);
  // R3
  alloc_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ev |-> ($countones(v_vec) < ENTRIES));

  // R5
  fill_queues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_hit_ev |=> rdy_valid);

  // R7
  drain_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && !rdy_last) |=> rdy_valid);

  // R9
  free_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_ev && !alloc_ev) |=> ($countones(v_vec) < $past($countones(v_vec))));

  // R11
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_pop && !rdy_valid && !alloc_ev) |=> $stable(v_vec));
endmodule

bind mshr_table mshr_table_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .v_vec(v_vec), .alloc_ev(alloc_ev),
  .fill_hit_ev(fill_hit_ev), .pop_ev(pop_ev), .free_ev(free_ev),
  .rdy_valid(rdy_valid), .rdy_last(rdy_last), .rdy_pop(rdy_pop));

// File: tb/tb_mshr_table.sv
module tb_mshr_table;
  localparam int AW = 16;
  localparam int IDW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] probe_addr = '0;
  logic probe_hit, probe_full;
  logic add_valid = 1'b0;
  logic [AW-1:0] add_addr = '0;
  logic [IDW-1:0] add_id = '0;
  logic add_atomic = 1'b0;
  logic add_ok;
  logic fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic fill_atomic;
  logic rdy_valid;
  logic [IDW-1:0] rdy_id;
  logic rdy_last;
  logic rdy_pop = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mshr_table dut (
    .clk(clk), .rst_n(rst_n), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .probe_full(probe_full), .add_valid(add_valid), .add_addr(add_addr),
    .add_id(add_id), .add_atomic(add_atomic), .add_ok(add_ok),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_atomic(fill_atomic),
    .rdy_valid(rdy_valid), .rdy_id(rdy_id), .rdy_last(rdy_last), .rdy_pop(rdy_pop));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Let the inputs set at a falling edge act at the next rising edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input int a, input bit exp_hit, input bit exp_full, input string req);
    probe_addr = AW'(a);
    #1;
    check(probe_hit == exp_hit, {req, " probe_hit"}, int'(probe_hit), int'(exp_hit));
    check(probe_full == exp_full, {req, " probe_full"}, int'(probe_full), int'(exp_full));
  endtask

  task automatic add(input int a, input int id, input bit atom, input bit exp_ok, input string req);
    add_addr = AW'(a); add_id = IDW'(id); add_atomic = atom; add_valid = 1'b1;
    #1;
    check(add_ok == exp_ok, {req, " add_ok"}, int'(add_ok), int'(exp_ok));
    step();
    add_valid = 1'b0; add_atomic = 1'b0;
  endtask

  task automatic fill(input int a, input bit exp_atom, input string req);
    fill_addr = AW'(a); fill_valid = 1'b1;
    #1;
    check(fill_atomic == exp_atom, {req, " fill_atomic"}, int'(fill_atomic), int'(exp_atom));
    step();
    fill_valid = 1'b0;
  endtask

  task automatic pop_expect(input int id, input bit last, input string req);
    #1;
    check(rdy_valid == 1'b1, {req, " rdy_valid"}, int'(rdy_valid), 1);
    check(rdy_id == IDW'(id), {req, " rdy_id"}, int'(rdy_id), id);
    check(rdy_last == last, {req, " rdy_last"}, int'(rdy_last), int'(last));
    rdy_pop = 1'b1;
    step();
    rdy_pop = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    #1;
    check(rdy_valid == 1'b0, {req, " rdy_valid idle"}, int'(rdy_valid), 0);
  endtask

  task automatic t_reset();
    expect_idle("R1");
    probe(16'h0100, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_merge_and_drain();
    add(16'h0100, 1, 1'b0, 1'b1, "R4");
    probe(16'h0100, 1'b1, 1'b0, "R2");
    probe(16'h0200, 1'b0, 1'b0, "R2");
    add(16'h0100, 2, 1'b0, 1'b1, "R4");
    add(16'h0100, 3, 1'b0, 1'b1, "R4");
    probe(16'h0100, 1'b1, 1'b1, "R3");
    add(16'h0100, 4, 1'b0, 1'b0, "R3");
    fill(16'h0100, 1'b0, "R6");
    pop_expect(1, 1'b0, "R7");
    pop_expect(2, 1'b0, "R7");
    pop_expect(3, 1'b1, "R7");  // dropped id 4 must not appear (R3)
    expect_idle("R9");
    probe(16'h0100, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_fill_order();
    add(16'h0B00, 10, 1'b0, 1'b1, "R8");
    add(16'h0C00, 20, 1'b0, 1'b1, "R8");
    add(16'h0C00, 21, 1'b0, 1'b1, "R8");
    fill(16'h0C00, 1'b0, "R8");
    fill(16'h0B00, 1'b0, "R8");
    pop_expect(20, 1'b0, "R8");
    pop_expect(21, 1'b1, "R8");
    pop_expect(10, 1'b1, "R8");
    expect_idle("R8");
  endtask

  task automatic t_atomic();
    add(16'h0D00, 5, 1'b0, 1'b1, "R6");
    add(16'h0D00, 6, 1'b1, 1'b1, "R6");
    fill(16'h0D00, 1'b1, "R6");
    pop_expect(5, 1'b0, "R6");
    pop_expect(6, 1'b1, "R6");
    add(16'h0D00, 7, 1'b0, 1'b1, "R9");
    fill(16'h0D00, 1'b0, "R9");
    pop_expect(7, 1'b1, "R9");
  endtask

  task automatic t_capacity();
    add(16'h1000, 30, 1'b0, 1'b1, "R3");
    add(16'h1100, 31, 1'b0, 1'b1, "R3");
    add(16'h1200, 32, 1'b0, 1'b1, "R3");
    add(16'h1300, 33, 1'b0, 1'b1, "R3");
    probe(16'h1400, 1'b0, 1'b1, "R3");
    add(16'h1400, 40, 1'b0, 1'b0, "R3");
    probe(16'h1000, 1'b1, 1'b0, "R4");
    add(16'h1000, 34, 1'b0, 1'b1, "R4");
    probe(16'h1400, 1'b0, 1'b1, "R3");
    fill(16'h1000, 1'b0, "R5");
    fill(16'h1100, 1'b0, "R5");
    fill(16'h1200, 1'b0, "R5");
    fill(16'h1300, 1'b0, "R5");
    pop_expect(30, 1'b0, "R4");
    pop_expect(34, 1'b1, "R4");
    pop_expect(31, 1'b1, "R8");
    pop_expect(32, 1'b1, "R8");
    pop_expect(33, 1'b1, "R8");
    expect_idle("R3");
    probe(16'h1400, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_filled_leaves_match();
    add(16'h2000, 50, 1'b0, 1'b1, "R10");
    fill(16'h2000, 1'b0, "R10");
    probe(16'h2000, 1'b0, 1'b0, "R10");
    add(16'h2000, 51, 1'b1, 1'b1, "R10");
    fill(16'h2000, 1'b1, "R10");
    pop_expect(50, 1'b1, "R10");
    pop_expect(51, 1'b1, "R10");
    expect_idle("R10");
  endtask

  task automatic t_ignored_inputs();
    fill(16'h3000, 1'b0, "R5");
    expect_idle("R5");
    rdy_pop = 1'b1;
    step();
    rdy_pop = 1'b0;
    expect_idle("R11");
    add(16'h3100, 60, 1'b0, 1'b1, "R11");
    add(16'h3100, 61, 1'b0, 1'b1, "R11");
    rdy_pop = 1'b1;  // pop while nothing is ready
    step();
    rdy_pop = 1'b0;
    probe(16'h3100, 1'b1, 1'b0, "R11");
    fill(16'h3100, 1'b0, "R11");
    pop_expect(60, 1'b0, "R11");
    pop_expect(61, 1'b1, "R11");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_merge_and_drain();
    t_fill_order();
    t_atomic();
    t_capacity();
    t_filled_leaves_match();
    t_ignored_inputs();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule